// File: doc/BRIEF.md
# I2C Target Register File with Auto-Incrementing Pointer

This block is an I2C target with a fixed 7-bit address. It holds sixteen 8-bit registers that both the serial bus and a local parallel host port can reach. The SCL and SDA inputs pass through synchronizer flops. Start and stop conditions are found as SDA edges that occur while the synchronized SCL is high. The block answers only when the first byte of a transaction carries its own address.

In a write, the first byte after the address loads an internal register pointer. Each later byte is stored at the pointer, and the pointer then steps by one. In a read, the block sends bytes starting at the current pointer and steps the pointer after each one. The pointer keeps its value across a repeated start and across separate transactions. A master normally sets the pointer with a short write, issues a repeated start, and then reads.

Before each read byte, the block checks a local ready input. If the input is low, the block holds SCL low until it goes high. Both bus outputs are open-drain requests, so a 1 pulls the wire low.

Top module: `i2c_tgt_regfile`

## Requirements
- R1: After reset, scl_drive_low and sda_drive_low are both 0, so neither bus line is pulled.
- R2: An SDA fall while SCL is high is a start, and an SDA rise while SCL is high is a stop. A stop returns the target to idle. Bytes clocked after a stop with no new start get no ACK and write nothing.
- R3: The first byte after a start holds the address in bits 7:1 and the direction in bit 0 (0 = write, 1 = read). When bits 7:1 equal DEV_ADDR, the target pulls SDA low during the ninth clock.
- R4: When the address does not match, the target gives no ACK, writes no register and pulls no line until the next start.
- R5: In a write, the low 4 bits of the first data byte load the pointer. Each later byte is stored at the pointer and ACKed, and the pointer then steps by one.
- R6: The pointer wraps from 15 to 0, in writes and in reads alike.
- R7: In a read, the target sends bytes MSB first, starting at the current pointer, and steps the pointer after each byte. The pointer persists across a repeated start and across transactions.
- R8: A master NACK on a read byte ends the read. The target releases SDA, so any further clocks read 0xFF.
- R9: When a read byte is due and rd_ready is 0, the target holds scl_drive_low at 1 until rd_ready is 1, and then sends the correct byte.
- R10: When host_we is 1, host_wdata is written to register host_addr. host_rdata shows register host_addr one clock after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL wire level |
| sda_i | input | 1 | SDA wire level |
| rd_ready | input | 1 | Local read data is ready; while low, SCL is stretched before a read byte |
| scl_drive_low | output | 1 | 1 pulls SCL low |
| sda_drive_low | output | 1 | 1 pulls SDA low |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 4 | Host register index |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |

## Verification
The bench writes bursts that start at different pointers, including one that wraps past register 15. This separates a correct auto-increment from a fixed address or an off-by-one store. Reads follow a pointer write and a repeated start, and a second read transaction then shows whether the pointer persisted. A foreign address and bytes clocked after a stop show that the target stays silent and writes nothing. A read held back by rd_ready, and extra clocks after a NACK, show whether the target stretches SCL and releases SDA at the right times.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WBYTE,
    ST_WACK,
    ST_LOAD,
    ST_TX,
    ST_RACK
  } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
// Synchronizes the bus wires and flags edges, start and stop. STAGES must be >= 2.
module i2c_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = ~scl_q & scl_s;
  assign scl_fall  = scl_q & ~scl_s;
  assign start_det = scl_q & scl_s & sda_q & ~sda_s;
  assign stop_det  = scl_q & scl_s & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_tgt_regs.sv
// Register storage with a host port and a bus port; reads are registered.
module i2c_tgt_regs #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (bus_we)  mem[bus_addr]  <= bus_wdata;
    if (host_we) mem[host_addr] <= host_wdata;
    host_rdata <= mem[host_addr];
    bus_rdata  <= mem[bus_addr];
  end
endmodule

// File: rtl/i2c_tgt_core.sv
// Byte engine: address match, pointer handling, ACK, transmit and clock stretch.
module i2c_tgt_core
  import i2c_tgt_pkg::*;
#(
  parameter int         DW       = 8,
  parameter int         AW       = 4,
  parameter logic [6:0] DEV_ADDR = 7'h42
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          rd_ready,
  input  logic [DW-1:0] bus_rdata,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          sda_low,
  output logic          scl_low
);
  localparam int CW = $clog2(DW + 1);

  tgt_state_e    st;
  logic [DW-1:0] sh;
  logic [CW-1:0] cnt;
  logic [AW-1:0] ptr;
  logic          rw, first, mack;
  logic          byte_in_done, rx_end, ptr_load;

  assign byte_in_done = (cnt == CW'(DW));
  assign rx_end    = (st == ST_WBYTE) && scl_fall && byte_in_done && !start_det && !stop_det;
  assign ptr_load  = rx_end && first;
  assign bus_we    = rx_end && !first;
  assign bus_addr  = ptr;
  assign bus_wdata = sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; sh <= '0; cnt <= '0; ptr <= '0;
      rw <= 1'b0; first <= 1'b0; mack <= 1'b0;
      sda_low <= 1'b0; scl_low <= 1'b0;
    end else if (start_det) begin
      st <= ST_ADDR; cnt <= '0; sda_low <= 1'b0; scl_low <= 1'b0;
    end else if (stop_det) begin
      st <= ST_IDLE; sda_low <= 1'b0; scl_low <= 1'b0;
    end else begin
      case (st)
        ST_ADDR, ST_WBYTE: begin
          if (scl_rise && !byte_in_done) begin
            sh  <= {sh[DW-2:0], sda_s};
            cnt <= cnt + 1'b1;
          end else if (scl_fall && byte_in_done) begin
            if (st == ST_ADDR) begin
              if (sh[DW-1 -: 7] == DEV_ADDR) begin
                st <= ST_AACK; sda_low <= 1'b1; rw <= sh[0];
              end else begin
                st <= ST_IDLE;
              end
            end else begin
              st <= ST_WACK; sda_low <= 1'b1; cnt <= '0;
              if (first) begin
                ptr   <= sh[AW-1:0];
                first <= 1'b0;
              end else begin
                ptr <= ptr + 1'b1;
              end
            end
          end
        end
        ST_AACK: if (scl_fall) begin
          sda_low <= 1'b0; cnt <= '0;
          if (rw) st <= ST_LOAD;
          else begin st <= ST_WBYTE; first <= 1'b1; end
        end
        ST_WACK: if (scl_fall) begin
          sda_low <= 1'b0; cnt <= '0; st <= ST_WBYTE;
        end
        ST_LOAD: begin
          if (rd_ready) begin
            sh <= bus_rdata; sda_low <= ~bus_rdata[DW-1];
            scl_low <= 1'b0; ptr <= ptr + 1'b1; cnt <= '0; st <= ST_TX;
          end else begin
            scl_low <= 1'b1;
          end
        end
        ST_TX: if (scl_fall) begin
          if (cnt == CW'(DW - 1)) begin
            sda_low <= 1'b0; st <= ST_RACK;
          end else begin
            sh <= {sh[DW-2:0], 1'b0}; sda_low <= ~sh[DW-2]; cnt <= cnt + 1'b1;
          end
        end
        ST_RACK: begin
          if (scl_rise) mack <= ~sda_s;
          if (scl_fall) st <= mack ? ST_LOAD : ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R9: stretch is held while local data is not ready
  a_r9_hold_until_ready: assert property (@(posedge clk) disable iff (rst)
    (scl_low && !rd_ready && !start_det && !stop_det) |=> scl_low);

  // R4: idle target pulls neither line
  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && !start_det) |=> (!sda_low && !scl_low));

  // R3: SDA drive only changes while SCL is low
  a_r3_sda_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
    (sda_low != $past(sda_low)) |-> !scl_s);

  // R6: pointer moves only by a load or a single step (wrapping)
  a_r6_ptr_step: assert property (@(posedge clk) disable iff (rst)
    ((ptr != $past(ptr)) && !$past(ptr_load)) |-> (ptr == AW'($past(ptr) + 1'b1)));

  // R8: a NACKed read byte ends in idle
  a_r8_nack_idle: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RACK && scl_fall && !mack && !start_det && !stop_det) |=> (st == ST_IDLE));
endmodule

// File: rtl/i2c_tgt_regfile.sv
module i2c_tgt_regfile #(
  parameter int         DW          = 8,
  parameter int         NREG        = 16,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR    = 7'h42
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    scl_i,
  input  logic                    sda_i,
  input  logic                    rd_ready,
  output logic                    scl_drive_low,
  output logic                    sda_drive_low,
  input  logic                    host_we,
  input  logic [$clog2(NREG)-1:0] host_addr,
  input  logic [DW-1:0]           host_wdata,
  output logic [DW-1:0]           host_rdata
);
  localparam int AW = $clog2(NREG);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic bus_we;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_tgt_core #(.DW(DW), .AW(AW), .DEV_ADDR(DEV_ADDR)) u_core (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .rd_ready(rd_ready),
    .bus_rdata(bus_rdata), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .sda_low(sda_drive_low), .scl_low(scl_drive_low)
  );

  i2c_tgt_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk(clk), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata)
  );
endmodule

// File: tb/sim_i2c_tgt_regfile.sv
module sim_i2c_tgt_regfile;
  localparam int Q = 8;
  localparam logic [7:0] WADR = 8'h84;
  localparam logic [7:0] RADR = 8'h85;
  localparam logic [7:0] XADR = 8'h8C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic rd_ready = 1'b1;
  logic host_we = 1'b0;
  logic [3:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic scl_drive_low, sda_drive_low;
  logic scl_line, sda_line;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  assign scl_line = ~(m_scl_low | scl_drive_low);
  assign sda_line = ~(m_sda_low | sda_drive_low);

  i2c_tgt_regfile u0 (
    .clk(clk), .rst(rst), .scl_i(scl_line), .sda_i(sda_line),
    .rd_ready(rd_ready), .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_scl_high();
    while (!scl_line) @(negedge clk);
  endtask

  task automatic m_start();
    m_sda_low = 1'b0; hold(Q);
    m_scl_low = 1'b0; wait_scl_high(); hold(Q);
    m_sda_low = 1'b1; hold(Q);
    m_scl_low = 1'b1; hold(Q);
  endtask

  task automatic m_stop();
    m_sda_low = 1'b1; hold(Q);
    m_scl_low = 1'b0; wait_scl_high(); hold(Q);
    m_sda_low = 1'b0; hold(Q);
  endtask

  task automatic m_bit(input bit b, output bit s);
    m_sda_low = !b; hold(Q);
    m_scl_low = 1'b0; wait_scl_high(); hold(Q);
    s = sda_line;
    m_scl_low = 1'b1; hold(Q);
  endtask

  task automatic m_send(input logic [7:0] d, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) m_bit(d[i], s);
    m_bit(1'b1, s);
    ack = !s;
  endtask

  task automatic m_recv(input bit give_ack, output logic [7:0] d);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      m_bit(1'b1, s);
      d[i] = s;
    end
    m_bit(!give_ack, s);
  endtask

  task automatic host_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); host_we = 1'b0;
  endtask

  task automatic host_rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); host_addr = a;
    @(negedge clk); d = host_rdata;
  endtask

  task automatic t_reset();
    chk("R1 scl_drive_low", scl_drive_low, 0);
    chk("R1 sda_drive_low", sda_drive_low, 0);
  endtask

  task automatic t_host();
    logic [7:0] d;
    host_wr(4'd12, 8'h6E);
    host_rd(4'd12, d);
    chk("R10 host readback", d, 8'h6E);
  endtask

  task automatic t_write();
    bit ack; logic [7:0] d;
    m_start();
    m_send(WADR, ack); chk("R3 address ack", ack, 1);
    m_send(8'h03, ack); chk("R5 pointer ack", ack, 1);
    m_send(8'hA1, ack); chk("R5 data ack", ack, 1);
    m_send(8'hB2, ack);
    m_send(8'hC3, ack);
    m_stop();
    host_rd(4'd3, d); chk("R5 reg3", d, 8'hA1);
    host_rd(4'd4, d); chk("R5 reg4", d, 8'hB2);
    host_rd(4'd5, d); chk("R5 reg5", d, 8'hC3);
  endtask

  task automatic t_wrap_write();
    bit ack; logic [7:0] d;
    m_start();
    m_send(WADR, ack);
    m_send(8'hFE, ack);
    m_send(8'h11, ack);
    m_send(8'h22, ack);
    m_send(8'h33, ack);
    m_stop();
    host_rd(4'd14, d); chk("R6 reg14", d, 8'h11);
    host_rd(4'd15, d); chk("R6 reg15", d, 8'h22);
    host_rd(4'd0, d);  chk("R6 wrap reg0", d, 8'h33);
  endtask

  task automatic t_foreign();
    bit ack; logic [7:0] d;
    host_wr(4'd2, 8'h5A);
    m_start();
    m_send(XADR, ack); chk("R4 no address ack", ack, 0);
    m_send(8'h02, ack); chk("R4 no data ack", ack, 0);
    m_send(8'h99, ack);
    chk("R4 sda released", sda_drive_low, 0);
    m_stop();
    host_rd(4'd2, d); chk("R4 reg2 unchanged", d, 8'h5A);
  endtask

  task automatic t_after_stop();
    bit ack; logic [7:0] d;
    host_wr(4'd6, 8'h10);
    m_start();
    m_send(WADR, ack);
    m_send(8'h06, ack);
    m_stop();
    m_send(WADR, ack); chk("R2 no ack after stop", ack, 0);
    m_send(8'h77, ack);
    m_stop();
    host_rd(4'd6, d); chk("R2 reg6 unchanged", d, 8'h10);
  endtask

  task automatic t_read();
    bit ack; logic [7:0] d;
    host_wr(4'd7, 8'h3C); host_wr(4'd8, 8'hC3);
    host_wr(4'd9, 8'h5F); host_wr(4'd10, 8'h81);
    m_start();
    m_send(WADR, ack);
    m_send(8'h07, ack);
    m_start();
    m_send(RADR, ack); chk("R3 read address ack", ack, 1);
    m_recv(1'b1, d); chk("R7 read reg7", d, 8'h3C);
    m_recv(1'b1, d); chk("R7 read reg8", d, 8'hC3);
    m_recv(1'b0, d); chk("R7 read reg9", d, 8'h5F);
    m_stop();
    m_start();
    m_send(RADR, ack);
    m_recv(1'b0, d); chk("R7 pointer persists", d, 8'h81);
    m_stop();
  endtask

  task automatic t_read_wrap_nack();
    bit ack; logic [7:0] d;
    host_wr(4'd15, 8'hE7); host_wr(4'd0, 8'h4D);
    m_start();
    m_send(WADR, ack);
    m_send(8'h0F, ack);
    m_start();
    m_send(RADR, ack);
    m_recv(1'b1, d); chk("R6 read reg15", d, 8'hE7);
    m_recv(1'b0, d); chk("R6 read wraps to reg0", d, 8'h4D);
    m_recv(1'b0, d); chk("R8 after nack bus idle", d, 8'hFF);
    chk("R8 sda released", sda_drive_low, 0);
    m_stop();
  endtask

  task automatic t_stretch();
    bit ack; logic [7:0] d;
    host_wr(4'd5, 8'h96);
    m_start();
    m_send(WADR, ack);
    m_send(8'h05, ack);
    m_start();
    rd_ready = 1'b0;
    m_send(RADR, ack);
    fork
      m_recv(1'b0, d);
      begin
        int k = 0;
        while (!scl_drive_low && k < 2000) begin @(negedge clk); k++; end
        hold(100);
        chk("R9 stretch held", scl_drive_low, 1);
        chk("R9 scl line low", scl_line, 0);
        rd_ready = 1'b1;
      end
    join
    chk("R9 byte after stretch", d, 8'h96);
    chk("R9 stretch released", scl_drive_low, 0);
    m_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    hold(5);
    rst = 1'b0;
    hold(3);
    t_reset();
    t_host();
    t_write();
    t_wrap_write();
    t_foreign();
    t_after_stop();
    t_read();
    t_read_wrap_nack();
    t_stretch();
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule